// File: doc/BRIEF.md
# Multi-Core Boot Release Controller

This block sequences the release of six processor cores out of reset. After a global reset it settles a 4-bit boot mode and picks a release policy from it. Mode 0 lets every core run. Mode 1 holds every core for an external host. Every other mode lets core 0 run and holds the rest. A held core stays held until its boot-complete bit is written to 1 through a small register bus. Any agent on that bus may write the bit, at any time. Each core also has a start-address register. The register loads a default when the policy is applied, and a host can rewrite it while the core is still held.

Three global reset sources exist. `por_n` is an asynchronous power-on reset. `warm_rst_req` and `sys_rst_req` are synchronous one-cycle requests. Power-on and warm resets take the mode from `mode_pins`. A system reset reuses the mode latched by the previous pin-based reset. A per-core local reset either restarts the core at once or parks it until its boot-complete bit is written again, depending on a per-core local mode bit. `boot_active` is high while any core is waiting for its boot-complete bit.

A sequencer with three states drives everything:
- **ST_HOLD**: every core is held, and the boot-complete and local-mode bits are cleared. The only transition, HOLD→SAMPLE, is taken on the next clock and latches the mode, from the pins or kept as it was.
- **ST_SAMPLE**: the policy is applied, the chosen boot-complete bits are set and the default addresses are loaded. The only transition, SAMPLE→RUN, is taken on the next clock.
- **ST_RUN**: the steady state. Bus writes and local resets are honoured only here.

The restart transition, any state→HOLD, is taken whenever `warm_rst_req` or `sys_rst_req` is sampled high. An active `por_n` forces ST_HOLD asynchronously.

Top module: `boot_release_ctrl`

## Requirements
- R1: After `por_n` rises, or after a `warm_rst_req` pulse, the mode is taken from `mode_pins` on the HOLD→SAMPLE edge. It reads back in bits [3:0] of the status register at word offset 2.
- R2: After a `sys_rst_req` pulse the latched mode is kept unchanged, whatever `mode_pins` shows.
- R3: In mode 0 every bit of `core_run` is 1 and `boot_active` is 0 by the second clock edge after reset release, which is within 4 cycles.
- R4: In mode 1 no core runs after release. Writing 1 to bit i of the boot-complete register (offset 0, core i at bit i) makes core i run from the next edge.
- R5: In modes 2 to 15, after release only core 0 runs, and cores 1 to 5 wait for their boot-complete bits.
- R6: `boot_active` is 1 and `core_run` is all zero while a global reset is in progress. `boot_active` stays 1 while any boot-complete bit is clear, and is 0 once all six are set.
- R7: The boot-complete bits are write-1-to-set. Writing 0 bits changes nothing, and the bits are cleared only by a global reset or by a host-mode local reset.
- R8: Each start address (offset 8+i for core i) defaults to 0x0080_0000. In modes 2 to 15, core 0 defaults to 0x0010_0000 instead.
- R9: A start-address write takes effect only while that core is held. While the core runs, the address is frozen.
- R10: The local-mode register (offset 1, bit i: 1 = host, 0 = immediate) resets to 0 on every global reset. A local reset of a core in immediate mode drops its `core_run` for exactly one cycle.
- R11: A local reset of a core in host mode clears its boot-complete bit. The core is held, and `boot_active` is 1, until that bit is written again.
- R12: Status bits [6:4] give the boot class of the latched mode: 0 for mode 0, 1 for mode 1, 2 for 9–10, 3 for 11–14, 4 for 5–8, 5 for 2–4 and 15.
- R13: When `warm_rst_req` and `sys_rst_req` are both high in one cycle, the warm request wins and the mode is taken from the pins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| warm_rst_req | input | 1 | Warm reset request, one cycle, mode from pins |
| sys_rst_req | input | 1 | System reset request, one cycle, keeps latched mode |
| mode_pins | input | 4 | Boot mode pins |
| local_rst | input | NUM_CORES | Per-core local reset pulse |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr, combinational |
| core_run | output | NUM_CORES | Per-core release; 1 = core out of reset |
| core_start_addr | output | NUM_CORES*32 | Start addresses, core i in bits [32i+31:32i] |
| boot_active | output | 1 | High while any core awaits boot-complete |

## Verification
On every cycle the assertions check the following:
- the sequencer takes SAMPLE→RUN;
- the latched mode is stable across a system reset;
- no core runs during a global reset;
- each policy yields its expected `core_run` pattern on the edge after release;
- boot-complete bits stay set while the core runs;
- a running core's start address never moves.

Only the bench scenarios can show the following:
- the mode source chosen by each reset type, including warm-over-system priority;
- the class code for each mode group;
- the default addresses for each policy;
- write-1-to-set behaviour through the bus;
- the one-cycle dip of an immediate local reset against the indefinite hold of a host-mode one.

// File: rtl/boot_rel_pkg.sv
package boot_rel_pkg;

    typedef enum logic [1:0] {
        ST_HOLD   = 2'd0,
        ST_SAMPLE = 2'd1,
        ST_RUN    = 2'd2
    } seq_state_t;

    typedef enum logic [1:0] {
        POL_ALL   = 2'd0,
        POL_HOST  = 2'd1,
        POL_CORE0 = 2'd2
    } rel_policy_t;

    typedef enum logic [2:0] {
        CLS_DIRECT = 3'd0,
        CLS_HOST   = 3'd1,
        CLS_ETH    = 3'd2,
        CLS_SERIAL = 3'd3,
        CLS_CELL   = 3'd4,
        CLS_OTHER  = 3'd5
    } boot_class_t;

    localparam logic [3:0] REG_BC     = 4'h0;
    localparam logic [3:0] REG_LMODE  = 4'h1;
    localparam logic [3:0] REG_STATUS = 4'h2;

    function automatic rel_policy_t policy_of(input logic [3:0] m);
        if (m == 4'd0)      return POL_ALL;
        else if (m == 4'd1) return POL_HOST;
        else                return POL_CORE0;
    endfunction

    function automatic boot_class_t class_of(input logic [3:0] m);
        case (m)
            4'd0:                        return CLS_DIRECT;
            4'd1:                        return CLS_HOST;
            4'd9, 4'd10:                 return CLS_ETH;
            4'd11, 4'd12, 4'd13, 4'd14:  return CLS_SERIAL;
            4'd5, 4'd6, 4'd7, 4'd8:      return CLS_CELL;
            default:                     return CLS_OTHER;
        endcase
    endfunction

endpackage

// File: rtl/boot_seq_fsm.sv
module boot_seq_fsm
    import boot_rel_pkg::*;
(
    input  logic       clk,
    input  logic       por_n,
    input  logic       warm_req,
    input  logic       sys_req,
    input  logic [3:0] mode_pins,
    output logic [3:0] mode_o,
    output logic       clear_all,
    output logic       release_go,
    output logic       running
);

    seq_state_t state_q;
    logic       use_pins_q;
    logic [3:0] mode_q;
    logic       restart;

    assign restart = warm_req | sys_req;
    assign mode_o  = mode_q;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            state_q <= ST_HOLD;
        end else if (restart) begin
            state_q <= ST_HOLD;
        end else begin
            unique case (state_q)
                ST_HOLD:   state_q <= ST_SAMPLE;
                ST_SAMPLE: state_q <= ST_RUN;
                ST_RUN:    state_q <= ST_RUN;
                default:   state_q <= ST_HOLD;
            endcase
        end
    end

    // Reset cause: warm outranks system when both arrive together
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            use_pins_q <= 1'b1;
        end else if (warm_req) begin
            use_pins_q <= 1'b1;
        end else if (sys_req) begin
            use_pins_q <= 1'b0;
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            mode_q <= 4'd0;
        end else if (state_q == ST_HOLD && !restart && use_pins_q) begin
            mode_q <= mode_pins;
        end
    end

    always_comb begin
        clear_all  = 1'b0;
        release_go = 1'b0;
        running    = 1'b0;
        unique case (state_q)
            ST_HOLD:   clear_all  = 1'b1;
            ST_SAMPLE: release_go = 1'b1;
            ST_RUN:    running    = 1'b1;
            default:   clear_all  = 1'b1;
        endcase
    end

    AST_SAMPLE_TO_RUN: assert property (@(posedge clk) disable iff (!por_n)
        (state_q == ST_SAMPLE && !restart) |=> (state_q == ST_RUN)); // R3

    AST_KEEP_LATCHED_MODE: assert property (@(posedge clk) disable iff (!por_n)
        (state_q == ST_HOLD && !use_pins_q && !warm_req) |=> $stable(mode_q)); // R2

    AST_RESTART_HOLD: assert property (@(posedge clk) disable iff (!por_n)
        restart |=> (state_q == ST_HOLD)); // R1

endmodule

// File: rtl/core_slot.sv
module core_slot #(
    parameter int               START_W    = 32,
    parameter logic [START_W-1:0] RESET_ADDR = 32'h0080_0000
) (
    input  logic               clk,
    input  logic               por_n,
    input  logic               clear_all,
    input  logic               release_go,
    input  logic               release_me,
    input  logic [START_W-1:0] def_addr,
    input  logic               running,
    input  logic               set_bc,
    input  logic               host_mode,
    input  logic               local_rst,
    input  logic               addr_we,
    input  logic [START_W-1:0] addr_wdata,
    output logic               run,
    output logic               bc,
    output logic [START_W-1:0] start_addr
);

    logic               bc_q;
    logic               lrst_q;
    logic [START_W-1:0] addr_q;
    logic               lrst_host;

    assign lrst_host = running & local_rst & host_mode;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            bc_q <= 1'b0;
        end else if (clear_all) begin
            bc_q <= 1'b0;
        end else if (release_go) begin
            bc_q <= release_me;
        end else if (lrst_host) begin
            bc_q <= 1'b0;
        end else if (running && set_bc) begin
            bc_q <= 1'b1;
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            lrst_q <= 1'b0;
        end else begin
            lrst_q <= running & local_rst & ~host_mode;
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            addr_q <= RESET_ADDR;
        end else if (release_go) begin
            addr_q <= def_addr;
        end else if (addr_we && !run) begin
            addr_q <= addr_wdata;
        end
    end

    assign run        = running & bc_q & ~lrst_q;
    assign bc         = bc_q;
    assign start_addr = addr_q;

    AST_BC_STICKY: assert property (@(posedge clk) disable iff (!por_n)
        (running && bc_q && !lrst_host) |=> bc_q); // R7

    AST_ADDR_FROZEN: assert property (@(posedge clk) disable iff (!por_n)
        run |=> $stable(addr_q)); // R9

    AST_IMM_DIP: assert property (@(posedge clk) disable iff (!por_n)
        (running && local_rst && !host_mode) |=> !run); // R10

endmodule

// File: rtl/boot_reg_if.sv
module boot_reg_if
    import boot_rel_pkg::*;
#(
    parameter int NUM_CORES = 6,
    parameter int DATA_W    = 32,
    parameter int START_W   = 32
) (
    input  logic                         clk,
    input  logic                         por_n,
    input  logic                         clear_all,
    input  logic                         running,
    input  logic                         reg_wr,
    input  logic [3:0]                   reg_addr,
    input  logic [DATA_W-1:0]            reg_wdata,
    input  logic [NUM_CORES-1:0]         bc_vec,
    input  logic [3:0]                   mode_q,
    input  logic [NUM_CORES*START_W-1:0] addr_flat,
    output logic [NUM_CORES-1:0]         set_bc,
    output logic [NUM_CORES-1:0]         host_mode,
    output logic [NUM_CORES-1:0]         addr_we,
    output logic [DATA_W-1:0]            reg_rdata
);

    logic [NUM_CORES-1:0] lmode_q;
    logic                 wr_ok;

    assign wr_ok     = running & reg_wr;
    assign set_bc    = (wr_ok && reg_addr == REG_BC) ? reg_wdata[NUM_CORES-1:0] : '0;
    assign host_mode = lmode_q;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            lmode_q <= '0;
        end else if (clear_all) begin
            lmode_q <= '0;
        end else if (wr_ok && reg_addr == REG_LMODE) begin
            lmode_q <= reg_wdata[NUM_CORES-1:0];
        end
    end

    for (genvar g = 0; g < NUM_CORES; g++) begin : g_we
        assign addr_we[g] = wr_ok & reg_addr[3] & (reg_addr[2:0] == 3'(g));
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_addr[3]) begin
            for (int i = 0; i < NUM_CORES; i++) begin
                if (reg_addr[2:0] == 3'(i)) begin
                    reg_rdata[START_W-1:0] = addr_flat[i*START_W +: START_W];
                end
            end
        end else if (reg_addr == REG_BC) begin
            reg_rdata[NUM_CORES-1:0] = bc_vec;
        end else if (reg_addr == REG_LMODE) begin
            reg_rdata[NUM_CORES-1:0] = lmode_q;
        end else if (reg_addr == REG_STATUS) begin
            reg_rdata[3:0] = mode_q;
            reg_rdata[6:4] = class_of(mode_q);
        end
    end

    AST_LMODE_CLEARED: assert property (@(posedge clk) disable iff (!por_n)
        clear_all |=> (lmode_q == '0)); // R10

endmodule

// File: rtl/boot_release_ctrl.sv
module boot_release_ctrl
    import boot_rel_pkg::*;
#(
    parameter int                 NUM_CORES  = 6,
    parameter int                 DATA_W     = 32,
    parameter int                 START_W    = 32,
    parameter logic [START_W-1:0] BASE_ADDR  = 32'h0080_0000,
    parameter logic [START_W-1:0] CORE0_ALT  = 32'h0010_0000
) (
    input  logic                         clk,
    input  logic                         por_n,
    input  logic                         warm_rst_req,
    input  logic                         sys_rst_req,
    input  logic [3:0]                   mode_pins,
    input  logic [NUM_CORES-1:0]         local_rst,
    input  logic                         reg_wr,
    input  logic [3:0]                   reg_addr,
    input  logic [DATA_W-1:0]            reg_wdata,
    output logic [DATA_W-1:0]            reg_rdata,
    output logic [NUM_CORES-1:0]         core_run,
    output logic [NUM_CORES*START_W-1:0] core_start_addr,
    output logic                         boot_active
);

    localparam logic [NUM_CORES-1:0] ALL_ONES = {NUM_CORES{1'b1}};

    logic [3:0]           mode_q;
    logic                 clear_all;
    logic                 release_go;
    logic                 running;
    rel_policy_t          policy;
    logic [NUM_CORES-1:0] bc_vec;
    logic [NUM_CORES-1:0] set_bc;
    logic [NUM_CORES-1:0] host_mode;
    logic [NUM_CORES-1:0] addr_we;

    boot_seq_fsm u_seq (
        .clk        (clk),
        .por_n      (por_n),
        .warm_req   (warm_rst_req),
        .sys_req    (sys_rst_req),
        .mode_pins  (mode_pins),
        .mode_o     (mode_q),
        .clear_all  (clear_all),
        .release_go (release_go),
        .running    (running)
    );

    assign policy = policy_of(mode_q);

    for (genvar g = 0; g < NUM_CORES; g++) begin : g_core
        logic               rel_me;
        logic [START_W-1:0] dflt;

        if (g == 0) begin : g_lead
            assign rel_me = (policy == POL_ALL) || (policy == POL_CORE0);
            assign dflt   = (policy == POL_CORE0) ? CORE0_ALT : BASE_ADDR;
        end else begin : g_follow
            assign rel_me = (policy == POL_ALL);
            assign dflt   = BASE_ADDR;
        end

        core_slot #(
            .START_W    (START_W),
            .RESET_ADDR (BASE_ADDR)
        ) u_slot (
            .clk        (clk),
            .por_n      (por_n),
            .clear_all  (clear_all),
            .release_go (release_go),
            .release_me (rel_me),
            .def_addr   (dflt),
            .running    (running),
            .set_bc     (set_bc[g]),
            .host_mode  (host_mode[g]),
            .local_rst  (local_rst[g]),
            .addr_we    (addr_we[g]),
            .addr_wdata (reg_wdata[START_W-1:0]),
            .run        (core_run[g]),
            .bc         (bc_vec[g]),
            .start_addr (core_start_addr[g*START_W +: START_W])
        );
    end

    boot_reg_if #(
        .NUM_CORES (NUM_CORES),
        .DATA_W    (DATA_W),
        .START_W   (START_W)
    ) u_regs (
        .clk       (clk),
        .por_n     (por_n),
        .clear_all (clear_all),
        .running   (running),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .bc_vec    (bc_vec),
        .mode_q    (mode_q),
        .addr_flat (core_start_addr),
        .set_bc    (set_bc),
        .host_mode (host_mode),
        .addr_we   (addr_we),
        .reg_rdata (reg_rdata)
    );

    assign boot_active = ~running | ~(&bc_vec);

    AST_HOLD_NONE_RUN: assert property (@(posedge clk) disable iff (!por_n)
        clear_all |-> (core_run == '0)); // R6

    AST_ACTIVE_FALL_ALL_RUN: assert property (@(posedge clk) disable iff (!por_n)
        $fell(boot_active) |-> (core_run == ALL_ONES)); // R6

    AST_MODE0_ALL: assert property (@(posedge clk) disable iff (!por_n)
        (release_go && policy == POL_ALL && !warm_rst_req && !sys_rst_req)
        |=> (core_run == ALL_ONES)); // R3

    AST_HOST_NONE: assert property (@(posedge clk) disable iff (!por_n)
        (release_go && policy == POL_HOST && !warm_rst_req && !sys_rst_req)
        |=> (core_run == '0)); // R4

    AST_CORE0_ONLY: assert property (@(posedge clk) disable iff (!por_n)
        (release_go && policy == POL_CORE0 && !warm_rst_req && !sys_rst_req)
        |=> (core_run == NUM_CORES'(1))); // R5

endmodule

// File: tb/tb_boot_release_ctrl.sv
module tb_boot_release_ctrl;

    localparam int N = 6;

    logic          clk = 1'b0;
    logic          por_n = 1'b0;
    logic          warm_rst_req = 1'b0;
    logic          sys_rst_req = 1'b0;
    logic [3:0]    mode_pins = 4'd0;
    logic [N-1:0]  local_rst = '0;
    logic          reg_wr = 1'b0;
    logic [3:0]    reg_addr = 4'd0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic [N-1:0]  core_run;
    logic [N*32-1:0] core_start_addr;
    logic          boot_active;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    boot_release_ctrl dut (
        .clk             (clk),
        .por_n           (por_n),
        .warm_rst_req    (warm_rst_req),
        .sys_rst_req     (sys_rst_req),
        .mode_pins       (mode_pins),
        .local_rst       (local_rst),
        .reg_wr          (reg_wr),
        .reg_addr        (reg_addr),
        .reg_wdata       (reg_wdata),
        .reg_rdata       (reg_rdata),
        .core_run        (core_run),
        .core_start_addr (core_start_addr),
        .boot_active     (boot_active)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    task automatic do_por(input logic [3:0] m);
        @(negedge clk);
        por_n = 1'b0;
        mode_pins = m;
        repeat (3) @(negedge clk);
        por_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic pulse_rst(input bit warm, input bit sys, input logic [3:0] m);
        @(negedge clk);
        mode_pins = m;
        warm_rst_req = warm;
        sys_rst_req = sys;
        @(negedge clk);
        warm_rst_req = 1'b0;
        sys_rst_req = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        reg_wr = 1'b1;
        reg_addr = a;
        reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic t_reset_state();
        @(negedge clk);
        check("R6 run during por", 32'(core_run), 32'h0);
        check("R6 active during por", 32'(boot_active), 32'h1);
    endtask

    task automatic t_mode0();
        logic [31:0] d;
        do_por(4'd0);
        check("R3 mode0 all run", 32'(core_run), 32'h3f);
        check("R3 mode0 active low", 32'(boot_active), 32'h0);
        rd(4'h2, d);
        check("R1 R12 status mode0", d, 32'h00);
        rd(4'h8, d);
        check("R8 core0 addr mode0", d, 32'h0080_0000);
    endtask

    task automatic t_mode1();
        logic [31:0] d;
        do_por(4'd1);
        check("R4 mode1 none run", 32'(core_run), 32'h0);
        check("R6 mode1 active", 32'(boot_active), 32'h1);
        rd(4'h2, d);
        check("R12 status mode1", d, 32'h11);
        wr(4'hA, 32'h0000_1234);
        rd(4'hA, d);
        check("R9 held addr write", d, 32'h0000_1234);
        wr(4'h0, 32'h04);
        check("R4 bc2 releases core2", 32'(core_run), 32'h04);
        wr(4'hA, 32'h0000_5555);
        rd(4'hA, d);
        check("R9 running addr frozen", d, 32'h0000_1234);
        wr(4'h0, 32'h00);
        rd(4'h0, d);
        check("R7 zero write no effect", d, 32'h04);
        check("R7 run unchanged", 32'(core_run), 32'h04);
        wr(4'h0, 32'h3b);
        check("R4 all released", 32'(core_run), 32'h3f);
        check("R6 active low after all bc", 32'(boot_active), 32'h0);
    endtask

    task automatic t_other_modes();
        logic [31:0] d;
        do_por(4'd9);
        check("R5 mode9 core0 only", 32'(core_run), 32'h01);
        check("R6 mode9 active", 32'(boot_active), 32'h1);
        rd(4'h8, d);
        check("R8 core0 alt addr", d, 32'h0010_0000);
        rd(4'h9, d);
        check("R8 core1 base addr", d, 32'h0080_0000);
        rd(4'h2, d);
        check("R12 class eth", d, 32'h29);
        pulse_rst(1'b0, 1'b1, 4'd1);
        rd(4'h2, d);
        check("R2 sys keeps mode", d, 32'h29);
        check("R2 sys policy core0", 32'(core_run), 32'h01);
        pulse_rst(1'b1, 1'b0, 4'd1);
        rd(4'h2, d);
        check("R1 warm takes pins", d, 32'h11);
        check("R1 warm mode1 none run", 32'(core_run), 32'h0);
        pulse_rst(1'b1, 1'b1, 4'd0);
        rd(4'h2, d);
        check("R13 warm wins", d, 32'h00);
        check("R13 mode0 run", 32'(core_run), 32'h3f);
        pulse_rst(1'b1, 1'b0, 4'd12);
        rd(4'h2, d);
        check("R12 class serial", d, 32'h3c);
        pulse_rst(1'b1, 1'b0, 4'd6);
        rd(4'h2, d);
        check("R12 class cell", d, 32'h46);
        pulse_rst(1'b1, 1'b0, 4'd3);
        rd(4'h2, d);
        check("R12 class other", d, 32'h53);
        check("R5 mode3 core0 only", 32'(core_run), 32'h01);
    endtask

    task automatic t_local();
        logic [31:0] d;
        do_por(4'd0);
        wr(4'h1, 32'h02);
        rd(4'h1, d);
        check("R10 lmode write", d, 32'h02);
        local_rst = 6'h04;
        @(negedge clk);
        local_rst = '0;
        check("R10 immediate dip", 32'(core_run), 32'h3b);
        @(negedge clk);
        check("R10 immediate back", 32'(core_run), 32'h3f);
        local_rst = 6'h02;
        @(negedge clk);
        local_rst = '0;
        check("R11 host held", 32'(core_run), 32'h3d);
        check("R11 active high", 32'(boot_active), 32'h1);
        repeat (3) @(negedge clk);
        rd(4'h0, d);
        check("R11 bc cleared", d, 32'h3d);
        check("R11 still held", 32'(core_run), 32'h3d);
        wr(4'h0, 32'h02);
        check("R11 rewrite releases", 32'(core_run), 32'h3f);
        check("R11 active low", 32'(boot_active), 32'h0);
        pulse_rst(1'b1, 1'b0, 4'd0);
        rd(4'h1, d);
        check("R10 lmode cleared", d, 32'h00);
    endtask

    initial begin
        t_reset_state();
        t_mode0();
        t_mode1();
        t_other_modes();
        t_local();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 20000; i++) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule